// File: doc/BRIEF.md
# Correlated Bursty Arrival Source

This block produces packet arrivals for one input of a slotted switch. The arrivals follow a three-state Markov chain with one idle phase and two burst phases. In each slot the source either sends nothing or offers one packet tagged with a destination port in the range 0 to NUM_PORTS-1. Every packet of one burst goes to the same destination. Each new burst draws its destination uniformly at random. Arrivals in neighbouring slots are therefore correlated, unlike a Bernoulli source where each slot is drawn on its own.

Two 16-bit thresholds set the behaviour. `idle_thr` is the idle probability as a fraction of 65536, and `cont_thr` is the probability that a burst continues. All randomness comes from internal LFSR lanes, and their seed can be reloaded at run time.

There are two burst phases so that a burst can hand over directly to a new burst, to a new destination and with no idle slot between them. Each such handover changes the phase code, so it can be seen at the pins.

The packet output is a valid/ready stream:
- A packet slot completes only when `pkt_valid` and `pkt_ready` are both high at a clock edge.
- While a packet is refused, the packet and the chain stay frozen.
- An idle slot always completes on the next edge, whatever `pkt_ready` is.

Top module: `mbt_burst_source`

## Requirements
- R1: After reset, `pkt_valid` is 0 and `burst_phase` is 0 (idle).
- R2: Three LFSR lanes (0: idle test, 1: continue test, 2: destination) supply the random samples. Each lane is 16 bits, and its current value is its sample for the current slot. A lane advances 16 single steps per completed slot. One single step shifts right; if the bit shifted out was 1, the result is XORed with 0xB400. After reset, lane k holds `RESET_SEED ^ (k*0x3C71 mod 65536)`. A zero seed value is replaced by 1.
- R3: `seed_load` high at an edge has three effects. It reloads lane k with `seed_value ^ (k*0x3C71 mod 65536)`, with zero replaced by 1. It forces the idle phase. It completes no slot. The same seed therefore always reproduces the same output sequence.
- R4: A slot completes at an edge when `pkt_valid` is 0 or `pkt_ready` is 1. While `pkt_valid` is 1 and `pkt_ready` is 0, the outputs and all state hold.
- R5: In the idle phase (code 0) `pkt_valid` is 0. When a slot completes in idle:
  - if the lane 0 sample is below `idle_thr`, the source stays idle;
  - otherwise it enters burst phase I (code 1) with a fresh destination.
- R6: When a slot completes in a burst phase (code 1 or 2) and the lane 1 sample is below `cont_thr`, the phase and the destination are kept.
- R7: When a slot completes in a burst phase and the burst does not continue:
  - if the lane 0 sample is below `idle_thr`, the source goes idle;
  - otherwise it switches to the other burst phase (1 to 2, 2 to 1) with a fresh destination.
- R8: A fresh destination is `(lane2_sample * NUM_PORTS) >> 16`. `pkt_dest` is always below NUM_PORTS while `pkt_valid` is 1.
- R9: With `idle_thr` = 0, the source never goes idle after leaving idle. With both thresholds 0, every accepted packet starts a new burst, so the phase alternates 1, 2, 1, 2 on consecutive slots.
- R10: With the outputs always accepted, the long-run fraction of slots that carry a packet approaches (1-Pa)/(1-Pa*Pb). Here Pa = idle_thr/65536 and Pb = cont_thr/65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Reloads the random lanes and restarts in idle |
| seed_value | input | 16 | Seed used by `seed_load` |
| idle_thr | input | 16 | Idle probability threshold (Pa * 65536) |
| cont_thr | input | 16 | Burst continue threshold (Pb * 65536) |
| pkt_valid | output | 1 | A packet is offered in this slot |
| pkt_ready | input | 1 | Downstream accepts the offered packet |
| pkt_dest | output | DEST_W | Destination port of the offered packet |
| burst_phase | output | 2 | 0 idle, 1 burst I, 2 burst II |

## Verification
The assertions check these rules on every cycle:
- the offer holds under back-pressure;
- the destination stays in range;
- a reload always returns to idle;
- the first phase after idle is burst I;
- no lane ever reaches the all-zero state;
- the threshold-zero rules (R9).

Only the bench scenarios can show the following:
- the exact slot-by-slot sequence of phases and destinations for given thresholds and seeds;
- that a repeated seed reproduces the same sequence;
- that the measured utilization over a long run matches the formula in R10.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  localparam int RAND_W = 16;
  localparam int NUM_LANES = 3;
  localparam int LANE_IDLE = 0;
  localparam int LANE_CONT = 1;
  localparam int LANE_DEST = 2;
  localparam logic [RAND_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [RAND_W-1:0] LANE_SALT = 16'h3C71;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_BURST_A = 2'd1,
    PH_BURST_B = 2'd2
  } phase_e;

  // Per-lane seed: base xor a lane-dependent salt, never zero.
  function automatic logic [RAND_W-1:0] lane_seed(input logic [RAND_W-1:0] base,
                                                  input int lane);
    logic [31:0]       salt;
    logic [RAND_W-1:0] v;
    salt = lane * 32'(LANE_SALT);
    v    = base ^ salt[RAND_W-1:0];
    if (v == '0) v = {{(RAND_W-1){1'b0}}, 1'b1};
    return v;
  endfunction

  // One right-shifting Galois step.
  function automatic logic [RAND_W-1:0] lfsr_once(input logic [RAND_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction
endpackage

// File: rtl/mbt_lfsr.sv
module mbt_lfsr
  import mbt_pkg::*;
#(
  parameter int                LANE       = 0,
  parameter logic [RAND_W-1:0] RESET_SEED = 16'hACE1,
  parameter int                STEPS      = RAND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [RAND_W-1:0] load_seed,
  output logic [RAND_W-1:0] sample
);
  logic [RAND_W-1:0] state_q;
  logic [RAND_W-1:0] jumped;

  // Several single steps per slot so consecutive samples do not overlap.
  always_comb begin
    jumped = state_q;
    for (int i = 0; i < STEPS; i++) jumped = lfsr_once(jumped);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= lane_seed(RESET_SEED, LANE);
    else if (load)    state_q <= lane_seed(load_seed, LANE);
    else if (advance) state_q <= jumped;
  end

  assign sample = state_q;

  p_lane_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  p_lane_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> state_q != $past(state_q));
endmodule

// File: rtl/mbt_dest_scale.sv
module mbt_dest_scale
  import mbt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DEST_W    = 2
) (
  input  logic [RAND_W-1:0] rnd,
  output logic [DEST_W-1:0] dest
);
  localparam int PROD_W = RAND_W + DEST_W;

  logic [PROD_W-1:0] prod;

  // Scale a uniform 16-bit sample onto 0..NUM_PORTS-1.
  assign prod = PROD_W'(rnd) * PROD_W'(NUM_PORTS);
  assign dest = DEST_W'(prod >> RAND_W);
endmodule

// File: rtl/mbt_chain.sv
module mbt_chain
  import mbt_pkg::*;
#(
  parameter int DEST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic              stay_idle,
  input  logic              keep_going,
  input  logic [DEST_W-1:0] fresh_dest,
  output phase_e            phase,
  output logic [DEST_W-1:0] dest
);
  phase_e            ph_q, ph_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic              take_dest;

  always_comb begin
    ph_d      = ph_q;
    dest_d    = dest_q;
    take_dest = 1'b0;
    if (restart) begin
      ph_d = PH_IDLE;
    end else if (advance) begin
      case (ph_q)
        PH_IDLE: begin
          if (!stay_idle) begin
            ph_d      = PH_BURST_A;
            take_dest = 1'b1;
          end
        end
        PH_BURST_A, PH_BURST_B: begin
          if (!keep_going) begin
            if (stay_idle) begin
              ph_d = PH_IDLE;
            end else begin
              ph_d      = (ph_q == PH_BURST_A) ? PH_BURST_B : PH_BURST_A;
              take_dest = 1'b1;
            end
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
    if (take_dest) dest_d = fresh_dest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      dest_q <= '0;
    end else begin
      ph_q   <= ph_d;
      dest_q <= dest_d;
    end
  end

  assign phase = ph_q;
  assign dest  = dest_q;

  p_idle_exit_to_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |=> (ph_q != PH_BURST_B));

  p_phase_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != phase_e'(2'd3));

  p_burst_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && ph_q != PH_IDLE && keep_going)
      |=> ($stable(ph_q) && $stable(dest_q)));

  p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && ph_q != PH_IDLE && !keep_going && !stay_idle)
      |=> (ph_q != $past(ph_q) && ph_q != PH_IDLE));
endmodule

// File: rtl/mbt_burst_source.sv
module mbt_burst_source
  import mbt_pkg::*;
#(
  parameter int                NUM_PORTS  = 4,
  parameter logic [RAND_W-1:0] RESET_SEED = 16'hACE1,
  localparam int               DEST_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [RAND_W-1:0] seed_value,
  input  logic [RAND_W-1:0] idle_thr,
  input  logic [RAND_W-1:0] cont_thr,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [DEST_W-1:0] pkt_dest,
  output logic [1:0]        burst_phase
);
  logic [RAND_W-1:0] lane_smp [NUM_LANES];
  logic              slot_done;
  logic [DEST_W-1:0] fresh_dest;
  logic [DEST_W-1:0] dest;
  phase_e            phase;

  // An idle slot always completes; a packet slot completes on acceptance.
  assign slot_done = !pkt_valid || pkt_ready;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    mbt_lfsr #(
      .LANE      (k),
      .RESET_SEED(RESET_SEED),
      .STEPS     (RAND_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (seed_load),
      .advance  (slot_done),
      .load_seed(seed_value),
      .sample   (lane_smp[k])
    );
  end

  mbt_dest_scale #(
    .NUM_PORTS(NUM_PORTS),
    .DEST_W   (DEST_W)
  ) u_scale (
    .rnd (lane_smp[LANE_DEST]),
    .dest(fresh_dest)
  );

  mbt_chain #(
    .DEST_W(DEST_W)
  ) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (seed_load),
    .advance   (slot_done),
    .stay_idle (lane_smp[LANE_IDLE] < idle_thr),
    .keep_going(lane_smp[LANE_CONT] < cont_thr),
    .fresh_dest(fresh_dest),
    .phase     (phase),
    .dest      (dest)
  );

  assign pkt_valid   = (phase != PH_IDLE);
  assign pkt_dest    = dest;
  assign burst_phase = phase;

  p_hold_offer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready && !seed_load)
      |=> (pkt_valid && $stable(pkt_dest) && $stable(burst_phase)));

  p_dest_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (32'(pkt_dest) < 32'(NUM_PORTS)));

  p_reload_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !pkt_valid);

  p_leave_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_valid && !seed_load && lane_smp[LANE_IDLE] >= idle_thr)
      |=> (burst_phase == 2'd1));

  p_no_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && !seed_load && idle_thr == '0) |=> pkt_valid);

  p_single_packet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && !seed_load && cont_thr == '0)
      |=> (burst_phase != $past(burst_phase)));
endmodule

// File: tb/mbt_burst_source_bench.sv
module mbt_burst_source_bench;
  localparam int          N_PORTS  = 4;
  localparam int          DW       = 2;
  localparam logic [15:0] RST_SEED = 16'hACE1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n      = 1'b0;
  logic          seed_load  = 1'b0;
  logic          pkt_ready  = 1'b0;
  logic [15:0]   seed_value = '0;
  logic [15:0]   idle_thr   = '0;
  logic [15:0]   cont_thr   = '0;
  logic          pkt_valid;
  logic [DW-1:0] pkt_dest;
  logic [1:0]    burst_phase;

  mbt_burst_source #(.NUM_PORTS(N_PORTS), .RESET_SEED(RST_SEED)) u_mbt_burst_source (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .idle_thr   (idle_thr),
    .cont_thr   (cont_thr),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_dest   (pkt_dest),
    .burst_phase(burst_phase)
  );

  int checks = 0;
  int errors = 0;

  // Reference model state, built from the requirements.
  logic [15:0] m_lane [3];
  int          m_ph;
  int          m_dest;
  string       m_tag;

  function automatic logic [15:0] ref_jump(input logic [15:0] s);
    logic [15:0] v;
    v = s;
    for (int i = 0; i < 16; i++) v = v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
    return v;
  endfunction

  function automatic logic [15:0] ref_seed(input logic [15:0] b, input int k);
    logic [31:0] salt;
    logic [15:0] v;
    salt = (k * 32'h3C71) & 32'hFFFF;
    v    = b ^ salt[15:0];
    if (v == 16'h0) v = 16'h1;
    return v;
  endfunction

  function automatic int ref_dest(input logic [15:0] r);
    longint p;
    p = longint'(r) * N_PORTS;
    return int'(p >>> 16);
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: compare, drive, advance model, move to next falling edge.
  task automatic step(input bit rdy, input bit ld, input logic [15:0] sd);
    bit idle_hit;
    bit cont_hit;
    int nd;
    check(m_tag, pkt_valid == (m_ph != 0), "pkt_valid", pkt_valid, (m_ph != 0));
    check(m_tag, int'(burst_phase) == m_ph, "burst_phase", burst_phase, m_ph);
    if (m_ph != 0) begin
      check(m_tag, int'(pkt_dest) == m_dest, "pkt_dest", pkt_dest, m_dest);
      check("R8", int'(pkt_dest) < N_PORTS, "dest range", pkt_dest, N_PORTS - 1);
    end
    pkt_ready  = rdy;
    seed_load  = ld;
    seed_value = sd;
    if (ld) begin
      for (int k = 0; k < 3; k++) m_lane[k] = ref_seed(sd, k);
      m_ph  = 0;
      m_tag = "R3";
    end else if (m_ph != 0 && !rdy) begin
      m_tag = "R4";
    end else begin
      idle_hit = m_lane[0] < idle_thr;
      cont_hit = m_lane[1] < cont_thr;
      nd       = ref_dest(m_lane[2]);
      if (m_ph == 0) begin
        m_tag = "R5";
        if (!idle_hit) begin
          m_ph   = 1;
          m_dest = nd;
        end
      end else if (cont_hit) begin
        m_tag = "R6";
      end else begin
        m_tag = "R7";
        if (idle_hit) m_ph = 0;
        else begin
          m_ph   = (m_ph == 1) ? 2 : 1;
          m_dest = nd;
        end
      end
      for (int k = 0; k < 3; k++) m_lane[k] = ref_jump(m_lane[k]);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int       hold_dest;
  int       hold_ph;
  int       exp_ph;
  int       rec_v [40];
  int       rec_p [40];
  int       rec_d [40];
  int       busy;
  real      pa, pb, expect_u, got_u;

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 3; k++) m_lane[k] = ref_seed(RST_SEED, k);
    m_ph   = 0;
    m_dest = 0;
    m_tag  = "R1";
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", pkt_valid == 1'b0, "reset pkt_valid", pkt_valid, 0);
    check("R1", burst_phase == 2'd0, "reset burst_phase", burst_phase, 0);

    // Random thresholds with corner blocks, random back-pressure and reloads.
    for (int blk = 0; blk < 15; blk++) begin
      idle_thr = 16'($urandom);
      cont_thr = 16'($urandom);
      if (blk == 3) idle_thr = 16'h0000;
      if (blk == 4) cont_thr = 16'h0000;
      if (blk == 5) idle_thr = 16'hFFFF;
      if (blk == 6) cont_thr = 16'hFFFF;
      for (int i = 0; i < 200; i++)
        step($urandom_range(3) != 0, $urandom_range(99) == 0, 16'($urandom));
    end

    // R4: refused packet holds.
    idle_thr = 16'h0000;
    cont_thr = 16'hFFFF;
    step(1'b1, 1'b1, 16'h00F0);
    step(1'b1, 1'b0, 16'h0);
    hold_dest = int'(pkt_dest);
    hold_ph   = int'(burst_phase);
    check("R4", pkt_valid == 1'b1, "offer present", pkt_valid, 1);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0, 16'h0);
      check("R4", int'(pkt_dest) == hold_dest, "held dest", pkt_dest, hold_dest);
      check("R4", int'(burst_phase) == hold_ph, "held phase", burst_phase, hold_ph);
      check("R4", pkt_valid == 1'b1, "held valid", pkt_valid, 1);
    end

    // R9: both thresholds zero -> phases alternate every slot.
    idle_thr = 16'h0000;
    cont_thr = 16'h0000;
    step(1'b1, 1'b1, 16'h7777);
    step(1'b1, 1'b0, 16'h0);
    exp_ph = 1;
    for (int i = 0; i < 10; i++) begin
      check("R9", int'(burst_phase) == exp_ph, "alternating phase", burst_phase, exp_ph);
      exp_ph = (exp_ph == 1) ? 2 : 1;
      step(1'b1, 1'b0, 16'h0);
    end

    // R3: identical seed reproduces the sequence.
    idle_thr = 16'h6000;
    cont_thr = 16'h9000;
    step(1'b1, 1'b1, 16'h1234);
    for (int i = 0; i < 40; i++) begin
      rec_v[i] = int'(pkt_valid);
      rec_p[i] = int'(burst_phase);
      rec_d[i] = pkt_valid ? int'(pkt_dest) : 0;
      step(1'b1, 1'b0, 16'h0);
    end
    step(1'b1, 1'b1, 16'h1234);
    for (int i = 0; i < 40; i++) begin
      check("R3", int'(pkt_valid) == rec_v[i], "replay valid", pkt_valid, rec_v[i]);
      check("R3", int'(burst_phase) == rec_p[i], "replay phase", burst_phase, rec_p[i]);
      if (pkt_valid)
        check("R3", int'(pkt_dest) == rec_d[i], "replay dest", pkt_dest, rec_d[i]);
      step(1'b1, 1'b0, 16'h0);
    end

    // R2: zero seed; lane 0 becomes 1, destinations follow lane 2.
    idle_thr = 16'h0000;
    cont_thr = 16'h0000;
    step(1'b1, 1'b1, 16'h0000);
    for (int i = 0; i < 30; i++) begin
      if (i > 0)
        check("R2", int'(pkt_dest) == m_dest, "lane-driven dest", pkt_dest, m_dest);
      step(1'b1, 1'b0, 16'h0);
    end

    // R10: long-run utilization.
    idle_thr = 16'h8000;
    cont_thr = 16'hC000;
    step(1'b1, 1'b1, 16'hBEEF);
    busy = 0;
    for (int i = 0; i < 20000; i++) begin
      if (pkt_valid) busy++;
      step(1'b1, 1'b0, 16'h0);
    end
    pa       = real'(idle_thr) / 65536.0;
    pb       = real'(cont_thr) / 65536.0;
    expect_u = (1.0 - pa) / (1.0 - pa * pb);
    got_u    = real'(busy) / 20000.0;
    check("R10", (got_u > expect_u - 0.08) && (got_u < expect_u + 0.08),
          "utilization x1000", longint'(got_u * 1000.0), longint'(expect_u * 1000.0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule